// File: doc/BRIEF.md
# Single to half precision converter

This block turns a binary32 floating-point word into its binary16 encoding, rounding to nearest with ties to even. Every input class has a defined result. Signed zero keeps its sign. Infinity stays infinity, and NaN stays NaN with its upper payload bits kept. Values too large for the half format become infinity. Small values become half subnormals, and values below half the smallest subnormal flush to zero.

The conversion logic is combinational. One output register holds the result. A result is captured only when `in_valid` is high, and `out_valid` marks that capture one cycle later.

A build parameter can widen the operand to a binary64 word. In that mode only the upper 32 bits feed the datapath. The lower 32 bits are still checked so that a NaN whose payload sits only in the low half does not turn into an infinity.

Top module: `sp2hp_converter`

## Requirements
- R1: An operand with an all-ones exponent field gives exponent 5'h1F and the operand's sign. Result bits [8:0] hold operand mantissa bits [21:13]. Result bit 9 is operand mantissa bit 22 ORed with "mantissa nonzero", so a NaN never becomes infinity.
- R2: A finite operand whose rebiased exponent (biased exponent − 112) is 31 or more gives a signed infinity: exponent 5'h1F and a zero mantissa.
- R3: When the rebiased exponent is 1..30, the result is the round-to-nearest-even value. A carry out of the mantissa moves into the exponent, so an input of 65520 or more becomes infinity.
- R4: When the rebiased exponent is −10..0, the result is a subnormal with exponent field 0, rounded to nearest even. A carry out of the mantissa gives the smallest normal, 0x0400.
- R5: A rebiased exponent below −10 gives a signed zero. This includes every zero and every binary32 subnormal input.
- R6: Result bit 15 always equals the operand sign bit.
- R7: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `out_half` changes only after an `in_valid` cycle and holds otherwise.
- R8: Synchronous reset clears `out_valid` and `out_half` to zero.
- R9: With `WIDE_IN=1` the operand is binary64. Only bits [63:32] are converted, using bias 1023 and a 20-bit mantissa fragment. The NaN test also covers bits [31:0], so a NaN with payload only in bits [31:0] gives 0x7E00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand valid this cycle |
| in_word | input | WIDE_IN ? 64 : 32 | Floating-point operand |
| out_valid | output | 1 | Result valid |
| out_half | output | 16 | binary16 result |

## Verification
The assertions assume that reset is held from time zero until the first clock edges have passed. They also assume that `in_word` is stable around each rising edge at which `in_valid` is sampled, because each check compares the output with the operand one cycle earlier. The bench drives the operand and the strobe only on falling edges and sets `in_valid` for a single cycle per operand. Between operands it changes `in_word` while the strobe is low, which exercises the hold rule without breaking either assumption.

// File: rtl/hcvt_pkg.sv
package hcvt_pkg;

    localparam int HALF_W     = 16;
    localparam int HALF_EXP_W = 5;
    localparam int HALF_MAN_W = 10;
    localparam int HALF_BIAS  = 15;
    localparam int REB_W      = 13;
    localparam int GUARD_W    = 26;

    typedef struct packed {
        logic                  sign;
        logic [HALF_EXP_W-1:0] expo;
        logic [HALF_MAN_W-1:0] frac;
    } half_t;

    typedef enum logic [1:0] {
        PATH_SPECIAL,
        PATH_OVERFLOW,
        PATH_NORMAL,
        PATH_TINY
    } path_e;

    function automatic int src_exp_w(bit wide);
        return wide ? 11 : 8;
    endfunction

    function automatic int src_man_w(bit wide);
        return wide ? 20 : 23;
    endfunction

    function automatic int src_bias(bit wide);
        return wide ? 1023 : 127;
    endfunction

    // Round up when the guard bit is set and either something below it or
    // the kept LSB just above it is set.
    function automatic logic round_up(logic [GUARD_W-1:0] mant,
                                      logic [GUARD_W-1:0] gbit);
        logic [GUARD_W-1:0] mask;
        mask = (gbit << 1) + gbit - GUARD_W'(1);
        return ((mant & gbit) != '0) && ((mant & mask) != '0);
    endfunction

endpackage

// File: rtl/hcvt_unpack.sv
module hcvt_unpack
    import hcvt_pkg::*;
#(
    parameter bit WIDE_IN = 1'b0,
    localparam int IN_W = WIDE_IN ? 64 : 32,
    localparam int EW   = src_exp_w(WIDE_IN),
    localparam int MW   = src_man_w(WIDE_IN)
) (
    input  logic [IN_W-1:0] word,
    output logic            sign,
    output logic [EW-1:0]   expo,
    output logic [MW-1:0]   frac,
    output logic            tail_nz
);
    logic [31:0] upper;

    generate
        if (WIDE_IN) begin : g_wide
            assign upper   = word[IN_W-1 -: 32];
            assign tail_nz = |word[IN_W-33:0];
        end else begin : g_narrow
            assign upper   = word;
            assign tail_nz = 1'b0;
        end
    endgenerate

    assign sign = upper[31];
    assign expo = upper[30 -: EW];
    assign frac = upper[MW-1:0];
endmodule

// File: rtl/hcvt_classify.sv
module hcvt_classify
    import hcvt_pkg::*;
#(
    parameter bit WIDE_IN = 1'b0,
    localparam int EW     = src_exp_w(WIDE_IN),
    localparam int REBIAS = src_bias(WIDE_IN) - HALF_BIAS
) (
    input  logic [EW-1:0]           expo,
    output path_e                   path,
    output logic signed [REB_W-1:0] reb
);
    always_comb begin
        reb = $signed(REB_W'(expo)) - $signed(REB_W'(REBIAS));
        if (expo == '1)
            path = PATH_SPECIAL;
        else if (reb >= 31)
            path = PATH_OVERFLOW;
        else if (reb <= 0)
            path = PATH_TINY;
        else
            path = PATH_NORMAL;
    end
endmodule

// File: rtl/hcvt_round.sv
module hcvt_round
    import hcvt_pkg::*;
#(
    parameter bit WIDE_IN = 1'b0,
    localparam int MW       = src_man_w(WIDE_IN),
    localparam int DROP     = MW - HALF_MAN_W,
    localparam int SH_BASE  = DROP + 1,
    localparam int UF_LIMIT = MW + 1
) (
    input  logic                    sign,
    input  logic [MW-1:0]           frac,
    input  logic                    tail_nz,
    input  path_e                   path,
    input  logic signed [REB_W-1:0] reb,
    output half_t                   result
);
    logic [GUARD_W-1:0]    frac_x;
    logic [GUARD_W-1:0]    mant_h;
    logic [GUARD_W-1:0]    gbit_norm;
    logic [GUARD_W-1:0]    gbit_tiny;
    logic [REB_W-1:0]      sh;
    logic [HALF_MAN_W-1:0] tiny_man;
    logic [HALF_MAN_W-1:0] nan_frac;
    logic                  payload_nz;

    always_comb begin
        frac_x     = GUARD_W'(frac);
        mant_h     = frac_x | (GUARD_W'(1) << MW);
        gbit_norm  = GUARD_W'(1) << (DROP - 1);
        sh         = REB_W'(SH_BASE) - $unsigned(reb);
        gbit_tiny  = (sh == '0) ? '0 : (GUARD_W'(1) << (sh - REB_W'(1)));
        tiny_man   = HALF_MAN_W'(mant_h >> sh);
        payload_nz = (frac != '0) || tail_nz;
        nan_frac   = frac[MW-1 -: HALF_MAN_W] | {payload_nz, {(HALF_MAN_W-1){1'b0}}};

        unique case (path)
            PATH_SPECIAL:
                result = '{sign: sign, expo: '1, frac: nan_frac};
            PATH_OVERFLOW:
                result = '{sign: sign, expo: '1, frac: '0};
            PATH_NORMAL:
                result = half_t'({sign, reb[HALF_EXP_W-1:0], frac[MW-1 -: HALF_MAN_W]}
                                 + HALF_W'(round_up(frac_x, gbit_norm)));
            default: begin
                if (sh > REB_W'(UF_LIMIT))
                    result = '{sign: sign, expo: '0, frac: '0};
                else
                    result = half_t'({sign, {HALF_EXP_W{1'b0}}, tiny_man}
                                     + HALF_W'(round_up(mant_h, gbit_tiny)));
            end
        endcase
    end
endmodule

// File: rtl/sp2hp_converter.sv
module sp2hp_converter
    import hcvt_pkg::*;
#(
    parameter bit WIDE_IN = 1'b0,
    localparam int IN_W = WIDE_IN ? 64 : 32,
    localparam int EW   = src_exp_w(WIDE_IN),
    localparam int MW   = src_man_w(WIDE_IN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_word,
    output logic              out_valid,
    output logic [HALF_W-1:0] out_half
);
    logic                    f_sign;
    logic [EW-1:0]           f_expo;
    logic [MW-1:0]           f_frac;
    logic                    f_tail_nz;
    path_e                   path;
    logic signed [REB_W-1:0] reb;
    half_t                   conv;

    hcvt_unpack #(.WIDE_IN(WIDE_IN)) u_unpack (
        .word    (in_word),
        .sign    (f_sign),
        .expo    (f_expo),
        .frac    (f_frac),
        .tail_nz (f_tail_nz)
    );

    hcvt_classify #(.WIDE_IN(WIDE_IN)) u_classify (
        .expo (f_expo),
        .path (path),
        .reb  (reb)
    );

    hcvt_round #(.WIDE_IN(WIDE_IN)) u_round (
        .sign    (f_sign),
        .frac    (f_frac),
        .tail_nz (f_tail_nz),
        .path    (path),
        .reb     (reb),
        .result  (conv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_half  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_half <= conv;
        end
    end
endmodule

// File: rtl/hcvt_checker.sv
module hcvt_checker
    import hcvt_pkg::*;
#(
    parameter bit WIDE_IN = 1'b0,
    localparam int IN_W   = WIDE_IN ? 64 : 32,
    localparam int EW     = src_exp_w(WIDE_IN),
    localparam int EXP_LO = IN_W - 1 - EW
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [IN_W-1:0]   in_word,
    input logic              out_valid,
    input logic [HALF_W-1:0] out_half
);
    logic exp_ones;
    logic exp_zero;
    logic mant_nz;

    assign exp_ones = (in_word[IN_W-2 -: EW] == '1);
    assign exp_zero = (in_word[IN_W-2 -: EW] == '0);
    assign mant_nz  = (in_word[EXP_LO-1:0] != '0);

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_drops_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_result_holds_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_half));

    assert_sign_kept_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_half[15] == $past(in_word[IN_W-1]));

    assert_special_exp_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && exp_ones) |=> out_half[14:10] == 5'h1F);

    assert_nan_stays_nan_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && exp_ones && mant_nz) |=> out_half[9]);

    assert_tiny_input_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && exp_zero) |=> out_half[14:0] == 15'd0);
endmodule

bind sp2hp_converter hcvt_checker #(.WIDE_IN(WIDE_IN)) u_chk (.*);

// File: tb/sp2hp_converter_bench.sv
`timescale 1ns/1ps
module sp2hp_converter_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_valid = 1'b0;
    logic [31:0] s_word = '0;
    logic        s_out_valid;
    logic [15:0] s_out_half;
    logic        w_valid = 1'b0;
    logic [63:0] w_word = '0;
    logic        w_out_valid;
    logic [15:0] w_out_half;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sp2hp_converter u_sp2hp_converter (
        .clk(clk), .rst(rst), .in_valid(s_valid), .in_word(s_word),
        .out_valid(s_out_valid), .out_half(s_out_half)
    );

    sp2hp_converter #(.WIDE_IN(1'b1)) u_sp2hp_converter_dbl (
        .clk(clk), .rst(rst), .in_valid(w_valid), .in_word(w_word),
        .out_valid(w_out_valid), .out_half(w_out_half)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic real pow2(int k);
        real r = 1.0;
        if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
        else        for (int i = 0; i < -k; i++) r = r / 2.0;
        return r;
    endfunction

    function automatic longint rne(real q);
        real    f = $floor(q);
        real    d = q - f;
        longint n = longint'(f);
        if (d > 0.5 || (d == 0.5 && n[0])) n++;
        return n;
    endfunction

    function automatic logic [15:0] ref_half(logic [31:0] x);
        logic        s = x[31];
        int          e = int'(x[30:23]);
        int          m = int'(x[22:0]);
        logic [9:0]  fr;
        real         a;
        longint      n;
        int          ex;
        if (e == 255) begin
            fr = x[22:13];
            fr[9] = fr[9] | (m != 0);
            return {s, 5'h1F, fr};
        end
        if (e == 0) a = real'(m) * pow2(-149);
        else        a = real'(m + 8388608) * pow2(e - 150);
        if (a >= 65520.0) return {s, 15'h7C00};
        if (a < pow2(-14)) begin
            n = rne(a * pow2(24));
            return {s, 15'(n)};
        end
        ex = 15;
        while (a < pow2(ex)) ex--;
        n = rne(a * pow2(10 - ex));
        return {s, 15'(longint'((ex + 15) * 1024) + n - 1024)};
    endfunction

    function automatic string req_of(int e);
        if (e == 255) return "R1";
        if (e >= 143) return "R2";
        if (e >= 113) return "R3";
        if (e >= 102) return "R4";
        return "R5";
    endfunction

    task automatic run_narrow(input logic [31:0] x, input string req);
        logic [15:0] expv;
        expv = ref_half(x);
        @(negedge clk);
        s_word  = x;
        s_valid = 1'b1;
        @(negedge clk);
        s_valid = 1'b0;
        check(s_out_valid === 1'b1 && s_out_half === expv, req,
              $sformatf("in=%h", x), {47'd0, s_out_valid, s_out_half}, {47'd0, 1'b1, expv});
        check(s_out_half[15] === x[31], "R6", $sformatf("sign in=%h", x),
              64'(s_out_half[15]), 64'(x[31]));
    endtask

    task automatic hold_narrow(input logic [31:0] junk);
        logic [15:0] prev;
        prev   = s_out_half;
        s_word = junk;
        @(negedge clk);
        check(s_out_valid === 1'b0 && s_out_half === prev, "R7", "hold without strobe",
              {47'd0, s_out_valid, s_out_half}, {48'd0, prev});
    endtask

    task automatic run_wide(input logic [63:0] x, input logic [15:0] expv);
        @(negedge clk);
        w_word  = x;
        w_valid = 1'b1;
        @(negedge clk);
        w_valid = 1'b0;
        check(w_out_valid === 1'b1 && w_out_half === expv, "R9",
              $sformatf("wide in=%h", x), {48'd0, w_out_half}, {48'd0, expv});
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        #750000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [22:0] pats [16];
        logic [22:0] lfsr;
        int          count;
        pats = '{23'h000000, 23'h000001, 23'h7FFFFF, 23'h400000,
                 23'h001000, 23'h003000, 23'h001001, 23'h000FFF,
                 23'h7FF000, 23'h7FE000, 23'h2AAAAA, 23'h555555,
                 23'h000800, 23'h200000, 23'h100000, 23'h7FF001};
        lfsr  = 23'h5A5A5;
        count = 0;

        repeat (3) @(negedge clk);
        // R8: reset leaves both outputs cleared
        check(s_out_valid === 1'b0 && s_out_half === 16'h0, "R8", "reset state",
              {47'd0, s_out_valid, s_out_half}, 64'd0);
        rst = 1'b0;

        // Directed corner values
        run_narrow(32'h477FE000, "R3");   // 65504 exact -> 0x7BFF
        run_narrow(32'h477FF000, "R3");   // 65520 tie at odd LSB -> infinity
        run_narrow(32'h3F801000, "R3");   // tie at even LSB stays 0x3C00
        run_narrow(32'h3F803000, "R3");   // tie at odd LSB rounds to 0x3C02
        run_narrow(32'h387FF000, "R4");   // subnormal carry -> 0x0400
        run_narrow(32'h33000000, "R4");   // 2^-25 tie -> zero
        run_narrow(32'h33000001, "R4");   // just above tie -> 0x0001
        run_narrow(32'h80000000, "R5");   // negative zero
        run_narrow(32'h7F800001, "R1");   // NaN with low payload
        run_narrow(32'hFF800000, "R1");   // negative infinity
        hold_narrow(32'h3F800000);

        for (int s = 0; s < 2; s++) begin
            for (int e = 0; e < 256; e++) begin
                for (int p = 0; p < 24; p++) begin
                    logic [22:0] m;
                    if (p < 16) m = pats[p];
                    else begin
                        lfsr = {lfsr[21:0], lfsr[22] ^ lfsr[17]};
                        m = lfsr;
                    end
                    run_narrow({s[0], e[7:0], m}, req_of(e));
                    count++;
                    if (count % 64 == 0) hold_narrow(~{s[0], e[7:0], m});
                end
            end
        end

        // R9: double-width operand path
        check(w_out_valid === 1'b0 && w_out_half === 16'h0, "R8", "wide reset state",
              {48'd0, w_out_half}, 64'd0);
        run_wide(64'h3FF0000000000000, 16'h3C00);
        run_wide(64'h40EFFC0000000000, 16'h7BFF);
        run_wide(64'h7FF0000000000001, 16'h7E00);
        run_wide(64'h7FF0000000000000, 16'h7C00);
        run_wide(64'hFFF0000000000000, 16'hFC00);
        run_wide(64'h7FF8000000000000, 16'h7E00);
        run_wide(64'h3E70000000000000, 16'h0001);
        run_wide(64'h3E60000000000000, 16'h0000);
        run_wide(64'h3E78000000000000, 16'h0002);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule